// File: doc/BRIEF.md
# Lane Symbol Pattern Generator

This block produces the symbol stream for every lane of a multi-lane serial display link, one 8-bit symbol with a control (K) flag per lane per clock. It either forwards the payload symbols it receives or replaces them with a test or training pattern. The test patterns are a pseudo-random 7-bit sequence and a repeating clock-like data symbol. The training patterns are a constant data symbol and a ten-symbol alignment sequence. The selected pattern decides whether the data symbols are XORed with a 16-bit scrambler stream. A separate disable bit can switch scrambling off without touching the pattern choice.

After the pattern stage, lanes at or above the configured lane count are forced to idle zeros. A reversal crossbar can then map logical lane i to physical lane N-1-i. Configuration is loaded through a single write strobe. The 8b/10b encoder sits downstream and takes the registered outputs directly.

Top module: `lg_pattern_gen`

## Requirements
- R1: While rst_n is low every lane_data and lane_k bit is 0. Reset also sets the configuration to pattern 0 with scrambling allowed, swap off and lane-count code 2, loads the pseudo-random register with 7'h7F and loads the scrambler with 16'hFFFF.
- R2: Pattern code 0 forwards each lane's payload symbol. When scrambling is on, data symbols (k=0) are XORed with the scrambler byte and K symbols pass unchanged. A payload symbol on input edge t appears on the outputs after that same edge.
- R3: The scrambler byte is built from state s over eight steps, for bit i=0..7: out[i]=s[15], then s={s[14:0], s[15]^s[4]^s[3]^s[2]}. The state advances by those eight steps every clock. The exception is a clock where pattern 0 is active and lane 0 carries K symbol 8'h1C: then the state is reloaded with 16'hFFFF.
- R4: Pattern code 4 puts the same pseudo-random byte on every active lane as a data symbol, scrambled. The byte is built from 7-bit state p, for bit i=0..7: b=p[6]^p[5], out[i]=b, p={p[5:0],b}. It advances every clock.
- R5: Pattern code 3 sends data symbol 8'h4A on every active lane, scrambled.
- R6: Pattern codes 1 and 2 are never scrambled, whatever the disable bit says. Code 1 sends data 8'h4A. Code 2 sends a ten-symbol cycle that starts at index 0 on the first clock of the pattern: index 0 and 2 are K 8'hBC, index 1 and 3 are data 8'hCB, index 4 to 9 are data 8'h4A.
- R7: With the scrambling-disable bit set, patterns 0, 3 and 4 go out unscrambled with the same pattern content. The scrambler and pseudo-random state keep advancing.
- R8: Lane-count code c enables logical lanes below min(2^c, 4): code 0 gives 1 lane, 1 gives 2, 2 and 3 give 4. Disabled logical lanes output data 0 with k=0.
- R9: With swap set, physical lane p carries logical lane 3-p. With swap clear, each lane carries itself.
- R10: Configuration fields are loaded only on a clock with cfg_we high and apply from the next clock on, to whole symbols. Field changes without cfg_we have no effect.
- R11: Pattern codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_pattern | input | 3 | Pattern code (0 payload, 1 train A, 2 train B, 3 clock-like, 4 pseudo-random) |
| cfg_scr_dis | input | 1 | Scrambling disable |
| cfg_swap | input | 1 | Lane reversal enable |
| cfg_lanes | input | 2 | Lane-count code |
| pay_data | input | NUM_LANES*8 | Payload symbols, lane i in bits 8i+7:8i |
| pay_k | input | NUM_LANES | Payload K flags, lane i in bit i |
| lane_data | output | NUM_LANES*8 | Physical lane symbols, registered |
| lane_k | output | NUM_LANES | Physical lane K flags, registered |

## Verification
A corrupted scrambler state shows on the next data symbol of any scrambled pattern as a wrong XOR mask. The same fault corrupts every later scrambled symbol until a reload symbol arrives. A wrong pseudo-random state shows within one clock in pattern 4. A wrong train-sequence index shows as a misplaced K symbol within ten clocks. A stale configuration register shows on the first clock after a write as wrong lane content, masking or ordering.

// File: rtl/lg_pkg.sv
package lg_pkg;
   localparam int SYM_W   = 8;
   localparam int LCNT_W  = 2;
   localparam int TR2_LEN = 10;

   localparam logic [SYM_W-1:0] SYM_CLKPAT = 8'h4A;
   localparam logic [SYM_W-1:0] SYM_COMMA  = 8'hBC;
   localparam logic [SYM_W-1:0] SYM_ALIGN  = 8'hCB;

   typedef enum logic [2:0] {
      PAT_PAYLOAD = 3'd0,
      PAT_TRAIN_A = 3'd1,
      PAT_TRAIN_B = 3'd2,
      PAT_CLOCKY  = 3'd3,
      PAT_PRBS    = 3'd4
   } pat_e;

   typedef struct packed {
      logic             k;
      logic [SYM_W-1:0] d;
   } sym_t;

   function automatic pat_e pat_decode(input logic [2:0] raw);
      return (raw > 3'd4) ? PAT_PAYLOAD : pat_e'(raw);
   endfunction

   function automatic logic pat_scrambles(input pat_e p);
      return !(p == PAT_TRAIN_A || p == PAT_TRAIN_B);
   endfunction

   function automatic sym_t train_b_sym(input logic [3:0] idx);
      sym_t s;
      case (idx)
         4'd0, 4'd2: s = '{k: 1'b1, d: SYM_COMMA};
         4'd1, 4'd3: s = '{k: 1'b0, d: SYM_ALIGN};
         default:    s = '{k: 1'b0, d: SYM_CLKPAT};
      endcase
      return s;
   endfunction
endpackage

// File: rtl/lg_prbs7.sv
module lg_prbs7 #(
   parameter logic [6:0] SEED = 7'h7F
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [7:0] byte_o
);
   logic [6:0] state_q;
   logic [6:0] state_nx;

   always_comb begin
      logic [6:0] s;
      logic       b;
      s = state_q;
      byte_o = '0;
      for (int i = 0; i < 8; i++) begin
         b = s[6] ^ s[5];
         byte_o[i] = b;
         s = {s[5:0], b};
      end
      state_nx = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= state_nx;
   end
endmodule

// File: rtl/lg_scrambler.sv
module lg_scrambler #(
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reseed_i,
   output logic [7:0]  byte_o,
   output logic [15:0] state_o
);
   logic [15:0] state_q;
   logic [15:0] state_nx;

   always_comb begin
      logic [15:0] s;
      s = state_q;
      byte_o = '0;
      for (int i = 0; i < 8; i++) begin
         byte_o[i] = s[15];
         s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
      end
      state_nx = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state_q <= SEED;
      else if (reseed_i) state_q <= SEED;
      else               state_q <= state_nx;
   end

   assign state_o = state_q;
endmodule

// File: rtl/lg_lane_map.sv
module lg_lane_map #(
   parameter int NUM_LANES = 4,
   parameter int SYM_W     = 8,
   parameter int LCNT_W    = 2
) (
   input  logic [NUM_LANES*SYM_W-1:0] log_d,
   input  logic [NUM_LANES-1:0]       log_k,
   input  logic [LCNT_W-1:0]          lcnt,
   input  logic                       swap,
   output logic [NUM_LANES*SYM_W-1:0] phy_d,
   output logic [NUM_LANES-1:0]       phy_k
);
   logic [NUM_LANES-1:0] live;

   always_comb begin
      for (int l = 0; l < NUM_LANES; l++)
         live[l] = (32'(l) < (32'd1 << lcnt));
   end

   for (genvar p = 0; p < NUM_LANES; p++) begin : g_phy
      localparam int MIR = NUM_LANES - 1 - p;
      always_comb begin
         if (swap) begin
            phy_d[p*SYM_W +: SYM_W] = live[MIR] ? log_d[MIR*SYM_W +: SYM_W] : '0;
            phy_k[p]                = live[MIR] & log_k[MIR];
         end else begin
            phy_d[p*SYM_W +: SYM_W] = live[p] ? log_d[p*SYM_W +: SYM_W] : '0;
            phy_k[p]                = live[p] & log_k[p];
         end
      end
   end
endmodule

// File: rtl/lg_pattern_gen.sv
module lg_pattern_gen
   import lg_pkg::*;
#(
   parameter int          NUM_LANES = 4,
   parameter logic [6:0]  PRBS_SEED = 7'h7F,
   parameter logic [15:0] SCR_SEED  = 16'hFFFF,
   parameter logic [7:0]  SR_CODE   = 8'h1C
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [2:0]                 cfg_pattern,
   input  logic                       cfg_scr_dis,
   input  logic                       cfg_swap,
   input  logic [LCNT_W-1:0]          cfg_lanes,
   input  logic [NUM_LANES*SYM_W-1:0] pay_data,
   input  logic [NUM_LANES-1:0]       pay_k,
   output logic [NUM_LANES*SYM_W-1:0] lane_data,
   output logic [NUM_LANES-1:0]       lane_k
);
   localparam int BUS_W = NUM_LANES * SYM_W;

   if (!(NUM_LANES == 1 || NUM_LANES == 2 || NUM_LANES == 4)) begin : g_bad_lanes
      $error("NUM_LANES must be 1, 2 or 4");
   end
   if (PRBS_SEED == '0) begin : g_bad_prbs
      $error("PRBS_SEED must be nonzero");
   end
   if (SCR_SEED == '0) begin : g_bad_scr
      $error("SCR_SEED must be nonzero");
   end

   pat_e              pat_q;
   logic              scr_dis_q;
   logic              swap_q;
   logic [LCNT_W-1:0] lanes_q;
   logic [3:0]        tr_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q     <= PAT_PAYLOAD;
         scr_dis_q <= 1'b0;
         swap_q    <= 1'b0;
         lanes_q   <= LCNT_W'(2);
      end else if (cfg_we) begin
         pat_q     <= pat_decode(cfg_pattern);
         scr_dis_q <= cfg_scr_dis;
         swap_q    <= cfg_swap;
         lanes_q   <= cfg_lanes;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tr_idx_q <= '0;
      else if (pat_q != PAT_TRAIN_B) tr_idx_q <= '0;
      else if (tr_idx_q == 4'(TR2_LEN - 1)) tr_idx_q <= '0;
      else                         tr_idx_q <= tr_idx_q + 4'd1;
   end

   logic [7:0]  prbs_byte;
   logic [7:0]  scr_byte;
   logic [15:0] scr_state;
   logic        sr_hit;
   logic        scr_on;

   assign sr_hit = (pat_q == PAT_PAYLOAD) && pay_k[0] && (pay_data[SYM_W-1:0] == SR_CODE);
   assign scr_on = pat_scrambles(pat_q) && !scr_dis_q;

   lg_prbs7 #(.SEED(PRBS_SEED)) u_prbs (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_o (prbs_byte)
   );

   lg_scrambler #(.SEED(SCR_SEED)) u_scr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reseed_i (sr_hit),
      .byte_o   (scr_byte),
      .state_o  (scr_state)
   );

   logic [BUS_W-1:0]     log_d;
   logic [NUM_LANES-1:0] log_k;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      sym_t raw;
      always_comb begin
         case (pat_q)
            PAT_TRAIN_A: raw = '{k: 1'b0, d: SYM_CLKPAT};
            PAT_TRAIN_B: raw = train_b_sym(tr_idx_q);
            PAT_CLOCKY:  raw = '{k: 1'b0, d: SYM_CLKPAT};
            PAT_PRBS:    raw = '{k: 1'b0, d: prbs_byte};
            default:     raw = '{k: pay_k[l], d: pay_data[l*SYM_W +: SYM_W]};
         endcase
         log_k[l]                = raw.k;
         log_d[l*SYM_W +: SYM_W] = (scr_on && !raw.k) ? (raw.d ^ scr_byte) : raw.d;
      end
   end

   logic [BUS_W-1:0]     phy_d;
   logic [NUM_LANES-1:0] phy_k;

   lg_lane_map #(.NUM_LANES(NUM_LANES), .SYM_W(SYM_W), .LCNT_W(LCNT_W)) u_map (
      .log_d (log_d),
      .log_k (log_k),
      .lcnt  (lanes_q),
      .swap  (swap_q),
      .phy_d (phy_d),
      .phy_k (phy_k)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_data <= '0;
         lane_k    <= '0;
      end else begin
         lane_data <= phy_d;
         lane_k    <= phy_k;
      end
   end
endmodule

// File: rtl/lg_pattern_gen_chk.sv
module lg_pattern_gen_chk #(
   parameter int          NUM_LANES = 4,
   parameter logic [15:0] SCR_SEED  = 16'hFFFF
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [2:0]             pat_q,
   input logic                   swap_q,
   input logic [1:0]             lanes_q,
   input logic                   sr_hit,
   input logic [15:0]            scr_state,
   input logic [NUM_LANES*8-1:0] lane_data,
   input logic [NUM_LANES-1:0]   lane_k
);
   logic plain_ok;
   always_comb begin
      plain_ok = (lane_k == '0);
      for (int i = 0; i < NUM_LANES; i++)
         if (!(lane_data[i*8 +: 8] == 8'h00 || lane_data[i*8 +: 8] == 8'h4A))
            plain_ok = 1'b0;
   end

   always @(negedge clk) begin
      if (!rst_n)
         AST_RESET_IDLE: assert (lane_data == '0 && lane_k == '0); // R1
   end

   AST_SCR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      scr_state != 16'h0000); // R3

   AST_SCR_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
      sr_hit |=> scr_state == SCR_SEED); // R3

   AST_TRAIN_A_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      pat_q == 3'd1 |=> plain_ok); // R6

   if (NUM_LANES > 1) begin : g_multi
      AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (lanes_q == 2'd0 && !swap_q) |=>
            (lane_data[NUM_LANES*8-1:8] == '0 && lane_k[NUM_LANES-1:1] == '0)); // R8

      AST_SWAP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
         (lanes_q == 2'd0 && swap_q) |=>
            (lane_data[(NUM_LANES-1)*8-1:0] == '0 && lane_k[NUM_LANES-2:0] == '0)); // R9
   end
endmodule

bind lg_pattern_gen lg_pattern_gen_chk #(.NUM_LANES(NUM_LANES), .SCR_SEED(SCR_SEED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pat_q     (pat_q),
   .swap_q    (swap_q),
   .lanes_q   (lanes_q),
   .sr_hit    (sr_hit),
   .scr_state (scr_state),
   .lane_data (lane_data),
   .lane_k    (lane_k)
);

// File: tb/sim_lg_pattern_gen.sv
module sim_lg_pattern_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_we = 1'b0;
   logic [2:0]  c_pat = '0;
   logic        c_dis = 1'b0;
   logic        c_swap = 1'b0;
   logic [1:0]  c_lanes = '0;
   logic [31:0] p_data = '0;
   logic [3:0]  p_k = '0;
   logic [31:0] lane_data;
   logic [3:0]  lane_k;

   int vectors = 0;
   int miss = 0;

   always #5 clk = ~clk;

   lg_pattern_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_pattern(c_pat),
      .cfg_scr_dis(c_dis), .cfg_swap(c_swap), .cfg_lanes(c_lanes),
      .pay_data(p_data), .pay_k(p_k), .lane_data(lane_data), .lane_k(lane_k)
   );

   // reference state
   logic [2:0]  m_pat = 3'd0;
   logic        m_dis = 1'b0;
   logic        m_swap = 1'b0;
   logic [1:0]  m_lanes = 2'd2;
   logic [6:0]  m_prbs = 7'h7F;
   logic [15:0] m_scr = 16'hFFFF;
   int          m_idx = 0;

   function automatic logic [14:0] ref_prbs(input logic [6:0] st);
      logic [6:0] r;
      logic [7:0] o;
      logic nb;
      r = st;
      o = '0;
      for (int i = 0; i < 8; i++) begin
         nb = r[6] ^ r[5];
         o[i] = nb;
         r = {r[5:0], nb};
      end
      return {r, o};
   endfunction

   function automatic logic [23:0] ref_scr(input logic [15:0] st);
      logic [15:0] r;
      logic [7:0] o;
      r = st;
      o = '0;
      for (int i = 0; i < 8; i++) begin
         o[i] = r[15];
         r = {r[14:0], r[15] ^ r[4] ^ r[3] ^ r[2]};
      end
      return {r, o};
   endfunction

   function automatic logic [8:0] ref_train_b(input int idx);
      if (idx == 0 || idx == 2) return {1'b1, 8'hBC};
      if (idx == 1 || idx == 3) return {1'b0, 8'hCB};
      return {1'b0, 8'h4A};
   endfunction

   task automatic cyc(input string tag);
      logic [31:0] ed;
      logic [3:0]  ek;
      @(posedge clk);
      ed = '0;
      ek = '0;
      if (rst_n) begin
         logic [2:0]  eff;
         logic        son;
         logic [14:0] pr;
         logic [23:0] sr;
         int          act;
         eff = (m_pat > 3'd4) ? 3'd0 : m_pat;
         son = (eff != 3'd1 && eff != 3'd2) && !m_dis;
         pr  = ref_prbs(m_prbs);
         sr  = ref_scr(m_scr);
         act = 1 << m_lanes;
         for (int l = 0; l < 4; l++) begin
            logic [7:0] d;
            logic       k;
            int         ph;
            case (eff)
               3'd1: begin d = 8'h4A; k = 1'b0; end
               3'd2: {k, d} = ref_train_b(m_idx);
               3'd3: begin d = 8'h4A; k = 1'b0; end
               3'd4: begin d = pr[7:0]; k = 1'b0; end
               default: begin d = p_data[l*8 +: 8]; k = p_k[l]; end
            endcase
            if (son && !k) d = d ^ sr[7:0];
            if (l >= act) begin d = '0; k = 1'b0; end
            ph = m_swap ? 3 - l : l;
            ed[ph*8 +: 8] = d;
            ek[ph] = k;
         end
         m_prbs = pr[14:8];
         m_scr  = (eff == 3'd0 && p_k[0] && p_data[7:0] == 8'h1C) ? 16'hFFFF : sr[23:8];
         m_idx  = (eff == 3'd2) ? ((m_idx == 9) ? 0 : m_idx + 1) : 0;
         if (c_we) begin
            m_pat = c_pat; m_dis = c_dis; m_swap = c_swap; m_lanes = c_lanes;
         end
      end
      #1;
      vectors++;
      if (lane_data !== ed || lane_k !== ek) begin
         miss++;
         $display("FAIL %s: lane_data=%h lane_k=%b expected %h %b", tag, lane_data, lane_k, ed, ek);
      end
   endtask

   task automatic write_cfg(input logic [2:0] pat, input logic dis, input logic sw,
                            input logic [1:0] ln, input string tag);
      c_we = 1'b1; c_pat = pat; c_dis = dis; c_swap = sw; c_lanes = ln;
      cyc(tag);
      c_we = 1'b0;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         p_data = $urandom;
         p_k = '0;
         cyc(tag);
      end
   endtask

   initial begin
      #(200000 * 10);
      miss++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: idle outputs under reset
      for (int i = 0; i < 4; i++) cyc("R1");
      rst_n = 1'b1;
      // R1, R2: default config straight after reset
      run(6, "R1");
      run(10, "R2");
      // R2: K symbols pass unchanged
      p_data = 32'hBC_7C_1C_BC; p_k = 4'b1010; cyc("R2");
      // R3: reload symbol on lane 0 then data checks the reseeded mask
      p_data = 32'h0000_001C; p_k = 4'b0001; cyc("R3");
      p_data = 32'h0; p_k = 4'b0000; cyc("R3");
      run(5, "R3");
      // R4
      write_cfg(3'd4, 1'b0, 1'b0, 2'd2, "R10");
      run(20, "R4");
      // R5
      write_cfg(3'd3, 1'b0, 1'b0, 2'd2, "R10");
      run(15, "R5");
      // R6: both training patterns, disable bit both ways
      write_cfg(3'd1, 1'b0, 1'b0, 2'd2, "R10");
      run(8, "R6");
      write_cfg(3'd2, 1'b1, 1'b0, 2'd3, "R10");
      run(25, "R6");
      write_cfg(3'd2, 1'b0, 1'b0, 2'd2, "R10");
      run(12, "R6");
      // R7: disable bit in scrambled modes
      write_cfg(3'd4, 1'b1, 1'b0, 2'd2, "R10");
      run(10, "R7");
      write_cfg(3'd0, 1'b1, 1'b0, 2'd2, "R10");
      run(10, "R7");
      // R8: one and two lanes
      write_cfg(3'd0, 1'b0, 1'b0, 2'd0, "R10");
      run(8, "R8");
      write_cfg(3'd3, 1'b0, 1'b0, 2'd1, "R10");
      run(8, "R8");
      // R9: reversal with four and with one lane
      write_cfg(3'd0, 1'b0, 1'b1, 2'd2, "R10");
      run(8, "R9");
      write_cfg(3'd4, 1'b0, 1'b1, 2'd0, "R10");
      run(8, "R9");
      // R10: fields change without the strobe
      c_pat = 3'd1; c_dis = 1'b1; c_swap = 1'b0; c_lanes = 2'd2;
      run(8, "R10");
      // R11: unused codes act as payload
      write_cfg(3'd6, 1'b0, 1'b0, 2'd2, "R10");
      run(8, "R11");
      p_data = 32'h0000_001C; p_k = 4'b0001; cyc("R11");
      run(4, "R11");
      // random phase
      for (int i = 0; i < 5000; i++) begin
         string tag;
         logic [2:0] e;
         e = (m_pat > 3'd4) ? 3'd0 : m_pat;
         case (e)
            3'd1, 3'd2: tag = "R6";
            3'd3: tag = m_dis ? "R7" : "R5";
            3'd4: tag = m_dis ? "R4/R7" : "R4";
            default: tag = m_dis ? "R7" : "R2";
         endcase
         c_we = ($urandom_range(39) == 0);
         c_pat = 3'($urandom_range(7));
         c_dis = ($urandom_range(3) == 0);
         c_swap = 1'($urandom_range(1));
         c_lanes = 2'($urandom_range(3));
         p_data = $urandom;
         for (int l = 0; l < 4; l++) p_k[l] = ($urandom_range(7) == 0);
         if ($urandom_range(15) == 0) begin
            p_data[7:0] = 8'h1C; p_k[0] = 1'b1;
         end
         cyc(tag);
      end
      c_we = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end
endmodule